// File: doc/BRIEF.md
# Radix-4 Digit Partial Product Generator

This combinational block forms every partial product of a signed weight times a signed multiplier word. The multiplier word of L bits is cut into L/2 two-bit digits. Each digit feeds its own small decoder. The decoder raises at most one of three select lines, and an AND/OR selection cell uses those lines to pass one of three prepared multiples of the weight, or zero. The triple of the weight is formed once and shared by every cell. The lower digits are unsigned and take the values 0 to 3. The top digit carries the sign of the multiplier, so its cell is offered w, -2w and -w.

The partial products leave the block unshifted, each W+2 bits wide, packed side by side. A downstream shift-and-add tree weights digit j by 4^j and sums the products to obtain w times x. The block has no registers.

Top module: `ppg_radix4`

## Requirements
- R1: Digit j is the bit pair x_i[2j+1:2j], for j = 0 to L/2-1, and each digit produces exactly one partial product.
- R2: A lower digit (j < L/2-1) of value 00 gives a partial product of zero.
- R3: A lower digit of value 01 gives w, sign-extended to W+2 bits.
- R4: A lower digit of value 10 gives 2w as a (W+2)-bit two's-complement value.
- R5: A lower digit of value 11 gives 3w as a (W+2)-bit two's-complement value.
- R6: The top digit is read as signed: 00 gives 0, 01 gives w, 10 gives -2w, 11 gives -w.
- R7: The sum over j of pp_j times 4^j equals w times x, with both read as two's complement, for every x, including the most negative x and the most negative w.
- R8: Partial product j occupies pp_o[(j+1)(W+2)-1 : j(W+2)].
- R9: Each partial product holds its exact value without wrap for every w, including 3w and -2w when w is the most negative weight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| w_i | input | W | Signed weight, two's complement |
| x_i | input | L | Signed multiplier word, two's complement |
| pp_o | output | (L/2)*(W+2) | Packed unshifted partial products, digit 0 in the low slice |

## Verification
The hardest corner is the most negative weight paired with a top digit of 10, where -2w becomes +2^W and needs every one of the W+2 bits, together with 3w of that weight on the lower digits. The stimulus reaches it by sweeping every multiplier value against a set of weights that includes both extremes, zero, plus and minus one and random values. Each partial product is checked against its digit value, and the reassembled sum is checked against the full product.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  typedef struct packed {
    logic one;
    logic two;
    logic three;
  } dsel_t;
endpackage

// File: rtl/ppg_dec.sv
module ppg_dec
  import ppg_pkg::*;
(
  input  logic [1:0] dig_i,
  output dsel_t      sel_o
);
  always_comb begin
    sel_o.one   =  dig_i[0] & ~dig_i[1];
    sel_o.two   = ~dig_i[0] &  dig_i[1];
    sel_o.three =  dig_i[0] &  dig_i[1];
  end

  always_comb begin
    a_r1_sel_onehot: assert ($onehot0({sel_o.one, sel_o.two, sel_o.three}))
      else $error("decoder raised more than one select");
  end
endmodule

// File: rtl/ppg_mult.sv
module ppg_mult #(
  parameter int W = 16
) (
  input  logic [W-1:0]   w_i,
  output logic [W+1:0]   p1_o,
  output logic [W+1:0]   p2_o,
  output logic [W+1:0]   p3_o,
  output logic [W+1:0]   n1_o,
  output logic [W+1:0]   n2_o
);
  localparam int WP = W + 2;

  always_comb begin
    p1_o = {{2{w_i[W-1]}}, w_i};
    p2_o = {p1_o[WP-2:0], 1'b0};
    p3_o = p1_o + p2_o;   // single shared adder
    n1_o = '0 - p1_o;
    n2_o = '0 - p2_o;
  end

  logic signed [WP+1:0] w_wide;
  assign w_wide = (WP+2)'(signed'(w_i));

  always_comb begin
    a_r9_triple_exact: assert ((WP+2)'(signed'(p3_o)) == w_wide * 3)
      else $error("3w wrapped");
    a_r9_neg_double_exact: assert ((WP+2)'(signed'(n2_o)) == -(w_wide * 2))
      else $error("-2w wrapped");
  end
endmodule

// File: rtl/ppg_aoc.sv
module ppg_aoc
  import ppg_pkg::*;
#(
  parameter int WP = 18
) (
  input  dsel_t          sel_i,
  input  logic [WP-1:0]  c1_i,
  input  logic [WP-1:0]  c2_i,
  input  logic [WP-1:0]  c3_i,
  output logic [WP-1:0]  pp_o
);
  assign pp_o = ({WP{sel_i.one}}   & c1_i)
              | ({WP{sel_i.two}}   & c2_i)
              | ({WP{sel_i.three}} & c3_i);
endmodule

// File: rtl/ppg_radix4.sv
module ppg_radix4
  import ppg_pkg::*;
#(
  parameter int L = 8,
  parameter int W = 16
) (
  input  logic [W-1:0]              w_i,
  input  logic [L-1:0]              x_i,
  output logic [(L/2)*(W+2)-1:0]    pp_o
);
  localparam int ND = L / 2;
  localparam int WP = W + 2;

  initial begin
    a_l_even: assert (L >= 4 && L % 2 == 0) else $error("L must be even and >= 4");
  end

  logic [WP-1:0] p1, p2, p3, n1, n2;

  ppg_mult #(.W(W)) u_mult (
    .w_i (w_i),
    .p1_o(p1),
    .p2_o(p2),
    .p3_o(p3),
    .n1_o(n1),
    .n2_o(n2)
  );

  logic [WP-1:0] w_ext;
  assign w_ext = {{2{w_i[W-1]}}, w_i};

  for (genvar j = 0; j < ND; j++) begin : g_dig
    dsel_t         sel;
    logic [WP-1:0] pp;
    logic [1:0]    dig;

    assign dig = x_i[2*j+1 -: 2];

    ppg_dec u_dec (
      .dig_i(dig),
      .sel_o(sel)
    );

    if (j == ND - 1) begin : g_top
      ppg_aoc #(.WP(WP)) u_aoc (
        .sel_i(sel),
        .c1_i (p1),
        .c2_i (n2),
        .c3_i (n1),
        .pp_o (pp)
      );
      always_comb begin
        if (dig == 2'b00) begin
          a_r6_top_zero: assert (pp == '0) else $error("top digit 0");
        end
        if (dig == 2'b11) begin
          a_r6_top_minus_one: assert (pp + w_ext == '0) else $error("top digit -1");
        end
      end
    end else begin : g_low
      ppg_aoc #(.WP(WP)) u_aoc (
        .sel_i(sel),
        .c1_i (p1),
        .c2_i (p2),
        .c3_i (p3),
        .pp_o (pp)
      );
      always_comb begin
        if (dig == 2'b00) begin
          a_r2_zero_digit: assert (pp == '0) else $error("digit 0 nonzero");
        end
        if (dig == 2'b01) begin
          a_r3_unit_digit: assert (pp == w_ext) else $error("digit 1 mismatch");
        end
        if (dig == 2'b10) begin
          a_r4_double_digit: assert (pp == {w_ext[WP-2:0], 1'b0}) else $error("digit 2 mismatch");
        end
      end
    end

    assign pp_o[j*WP +: WP] = pp;  // R8 packing
  end
endmodule

// File: tb/tb_ppg_radix4.sv
`timescale 1ns/1ps
module tb_ppg_radix4;
  localparam int L  = 8;
  localparam int W  = 16;
  localparam int ND = L / 2;
  localparam int WP = W + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0]           w;
  logic [L-1:0]           x;
  logic [ND*WP-1:0]       pp;

  int total = 0;
  int bad   = 0;

  ppg_radix4 #(.L(L), .W(W)) dut (
    .w_i (w),
    .x_i (x),
    .pp_o(pp)
  );

  function automatic longint slice_val(input logic [ND*WP-1:0] v, input int j);
    logic [WP-1:0] s;
    s = v[j*WP +: WP];
    return longint'(signed'(s));
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d (w=%0d x=%0d)", tag, act, exp,
               $signed(w), $signed(x));
    end
  endtask

  task automatic apply(input logic [W-1:0] wv, input logic [L-1:0] xv);
    longint wi, xi, sum, exp_pp;
    int d;
    @(negedge clk);
    w = wv;
    x = xv;
    @(posedge clk);
    #1;
    wi  = longint'(signed'(wv));
    xi  = longint'(signed'(xv));
    sum = 0;
    for (int j = 0; j < ND; j++) begin
      d = int'((xv >> (2*j)) & 3);
      if (j == ND - 1) begin
        exp_pp = (d >= 2) ? wi * (d - 4) : wi * d;
        chk("R6 top digit", slice_val(pp, j), exp_pp);
      end else begin
        exp_pp = wi * d;
        case (d)
          0: chk("R2 digit zero", slice_val(pp, j), exp_pp);
          1: chk("R3 digit one", slice_val(pp, j), exp_pp);
          2: chk("R4 digit two", slice_val(pp, j), exp_pp);
          default: chk("R5 digit three", slice_val(pp, j), exp_pp);
        endcase
      end
      sum += slice_val(pp, j) * (longint'(1) << (2*j));
    end
    // R1 R8 R9: slices at fixed positions, exact values, reassemble to product
    chk("R7 product", sum, wi * xi);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] wl [8];
    w = '0;
    x = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset-state style check: zero inputs give all-zero products (R2)
    @(negedge clk);
    chk("R2 idle zero", longint'(pp == '0), 1);

    wl[0] = '0;
    wl[1] = 16'h0001;
    wl[2] = 16'hFFFF;
    wl[3] = 16'h7FFF;
    wl[4] = 16'h8000;   // most negative weight, R9
    wl[5] = 16'h1234;
    wl[6] = 16'hC001;
    wl[7] = 16'h5555;
    for (int k = 0; k < 8; k++)
      for (int xv = 0; xv < (1 << L); xv++)
        apply(wl[k], L'(xv));
    for (int k = 0; k < 20; k++)
      for (int xv = 0; xv < (1 << L); xv += 7)
        apply(W'($urandom), L'(xv));
    // most negative x with most negative w
    apply(16'h8000, 8'h80);
    apply(16'h7FFF, 8'h80);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule